// File: doc/BRIEF.md
# Sixteen-Way Two-Bit-Age Set Replacement

This block holds the complete replacement state of a single cache set with sixteen ways. Every way stores a tag, a valid flag and a two-bit age. The age runs from 0, the most protected value, to 3, the value that makes a line a candidate for eviction. A requester offers one tag at a time. The block compares the tag with the valid ways and reports a hit together with the matching way. On a miss it installs the tag in a chosen way and reports which tag, if any, was pushed out.

Lines do not enter as most-recently-used. A new line starts at age 1. A hit on a line at age 2 or 3 brings it back to age 1, and a hit on a line at age 0 or 1 sets it to 0. When the set is full and no way has age 3, all ages step up together, one step per clock, until some way reaches 3. The request port holds ready low while these steps run. Every accepted request ends with a one-cycle completion pulse. A debug port shows the whole tag, valid and age state so the exact order of state changes can be checked.

Top module: `qage_set_repl`

## Requirements
- R1: After reset, every valid flag is 0, every age is 3 and req_ready is 1.
- R2: A request hits only when its tag equals the tag of a valid way. A tag that matches only an invalid way is a miss. On a hit, rsp_hit is 1 and rsp_way gives the matching way index.
- R3: On a hit, the hit way's age moves from 3 or 2 to 1, or from 1 or 0 to 0. Every other way, and every tag and valid flag, is unchanged.
- R4: On a miss in a set with an invalid way, the tag goes into the lowest-index invalid way. That way becomes valid with age 1, rsp_evict_valid is 0, and the ages of all other ways are unchanged.
- R5: On a miss in a full set, the victim is the lowest-index way with age 3. Its old tag appears on rsp_evict_tag with rsp_evict_valid 1, and the new tag goes in at age 1.
- R6: On a miss in a full set with no way at age 3, all sixteen ages rise by one per clock together, with req_ready low, until at least one way reaches 3. The fill of R5 then follows on the next clock.
- R7: rsp_done is a single-cycle pulse for each accepted request. It is high in the cycle after acceptance for a hit or a miss that needs no aging. Each aging step delays it by one further cycle. Debug encoding: way i uses dbg_age[2i+1:2i] and dbg_tag[TAG_W*i +: TAG_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_tag | input | TAG_W | Tag to look up |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Completed request was a hit |
| rsp_way | output | log2(WAYS) | Way that was hit or filled |
| rsp_evict_valid | output | 1 | A valid line was displaced |
| rsp_evict_tag | output | TAG_W | Tag of the displaced line |
| dbg_valid | output | WAYS | Valid flag per way |
| dbg_age | output | 2*WAYS | Age per way |
| dbg_tag | output | TAG_W*WAYS | Tag per way |

## Verification
The assertions assume that the requester raises req_valid only while req_ready is high. They also assume that no two valid ways hold the same tag, which holds because the block installs a tag only after it has missed. The R2 check also assumes that a hit completes exactly one cycle after its request, which it does because hits never age. The stimulus drives one request at a time and waits for its completion pulse before the next. It draws tags from a pool only a little larger than the set, so hits, fills into empty ways, direct evictions and aging runs of one, two and three steps all occur, including a set where every age is 0.

// File: rtl/qage_pkg.sv
package qage_pkg;
    localparam int AGE_W = 2;
    typedef logic [AGE_W-1:0] age_t;
    localparam age_t AGE_MAX = 2'd3;
    localparam age_t AGE_NEW = 2'd1;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_AGING = 1'b1
    } ctl_state_e;

    function automatic age_t age_promote(input age_t a);
        return (a >= 2'd2) ? 2'd1 : 2'd0;
    endfunction
endpackage

// File: rtl/qage_lowest.sv
module qage_lowest #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/qage_tag_match.sv
module qage_tag_match #(
    parameter int WAYS  = 16,
    parameter int TAG_W = 8
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            valid,
    input  logic [TAG_W-1:0]           probe,
    output logic [WAYS-1:0]            match
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == probe);
    end
endmodule

// File: rtl/qage_age_bank.sv
module qage_age_bank
    import qage_pkg::*;
#(
    parameter int WAYS = 16
) (
    input  age_t [WAYS-1:0] ages,
    output logic [WAYS-1:0] at_max,
    output age_t [WAYS-1:0] stepped
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign at_max[g]  = (ages[g] == AGE_MAX);
        assign stepped[g] = (ages[g] == AGE_MAX) ? AGE_MAX : ages[g] + 2'd1;
    end
endmodule

// File: rtl/qage_set_repl.sv
module qage_set_repl
    import qage_pkg::*;
#(
    parameter int WAYS  = 16,
    parameter int TAG_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [TAG_W-1:0]        req_tag,
    output logic                    req_ready,
    output logic                    rsp_done,
    output logic                    rsp_hit,
    output logic [WAY_W-1:0]        rsp_way,
    output logic                    rsp_evict_valid,
    output logic [TAG_W-1:0]        rsp_evict_tag,
    output logic [WAYS-1:0]         dbg_valid,
    output logic [2*WAYS-1:0]       dbg_age,
    output logic [TAG_W*WAYS-1:0]   dbg_tag
);
    typedef struct packed {
        ctl_state_e                    st;
        age_t [WAYS-1:0]               ages;
        logic [WAYS-1:0][TAG_W-1:0]    tags;
        logic [WAYS-1:0]               valid;
        logic [TAG_W-1:0]              pend_tag;
        logic                          done;
        logic                          hit;
        logic [WAY_W-1:0]              way;
        logic                          ev_valid;
        logic [TAG_W-1:0]              ev_tag;
    } repl_state_t;

    repl_state_t q, d;

    logic [WAYS-1:0]  match_vec;
    logic [WAYS-1:0]  at_max;
    age_t [WAYS-1:0]  stepped;
    logic             hit_found, inv_found, old_found;
    logic [WAY_W-1:0] hit_idx, inv_idx, old_idx;
    logic             accept;
    logic             fill_en;
    logic [WAY_W-1:0] fill_way;
    logic [TAG_W-1:0] fill_tag;

    qage_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .tags  (q.tags),
        .valid (q.valid),
        .probe (req_tag),
        .match (match_vec)
    );

    qage_lowest #(.N(WAYS)) u_hit_pick (
        .vec   (match_vec),
        .found (hit_found),
        .idx   (hit_idx)
    );

    qage_lowest #(.N(WAYS)) u_inv_pick (
        .vec   (~q.valid),
        .found (inv_found),
        .idx   (inv_idx)
    );

    qage_age_bank #(.WAYS(WAYS)) u_ages (
        .ages    (q.ages),
        .at_max  (at_max),
        .stepped (stepped)
    );

    qage_lowest #(.N(WAYS)) u_old_pick (
        .vec   (at_max),
        .found (old_found),
        .idx   (old_idx)
    );

    assign req_ready = (q.st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign fill_tag  = (q.st == ST_AGING) ? q.pend_tag : req_tag;
    assign fill_way  = inv_found ? inv_idx : old_idx;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        fill_en = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (hit_found) begin
                        d.ages[hit_idx] = age_promote(q.ages[hit_idx]);
                        d.done          = 1'b1;
                        d.hit           = 1'b1;
                        d.way           = hit_idx;
                        d.ev_valid      = 1'b0;
                        d.ev_tag        = '0;
                    end else if (inv_found || old_found) begin
                        fill_en = 1'b1;
                    end else begin
                        d.ages     = stepped;
                        d.pend_tag = req_tag;
                        d.st       = ST_AGING;
                    end
                end
            end
            ST_AGING: begin
                if (old_found) begin
                    fill_en = 1'b1;
                    d.st    = ST_IDLE;
                end else begin
                    d.ages = stepped;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (fill_en) begin
            d.tags[fill_way]  = fill_tag;
            d.valid[fill_way] = 1'b1;
            d.ages[fill_way]  = AGE_NEW;
            d.done            = 1'b1;
            d.hit             = 1'b0;
            d.way             = fill_way;
            d.ev_valid        = q.valid[fill_way];
            d.ev_tag          = q.valid[fill_way] ? q.tags[fill_way] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.ages     <= {WAYS{AGE_MAX}};
            q.tags     <= '0;
            q.valid    <= '0;
            q.pend_tag <= '0;
            q.done     <= 1'b0;
            q.hit      <= 1'b0;
            q.way      <= '0;
            q.ev_valid <= 1'b0;
            q.ev_tag   <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_done        = q.done;
    assign rsp_hit         = q.hit;
    assign rsp_way         = q.way;
    assign rsp_evict_valid = q.ev_valid;
    assign rsp_evict_tag   = q.ev_tag;
    assign dbg_valid       = q.valid;
    assign dbg_age         = q.ages;
    assign dbg_tag         = q.tags;

    // R2: a reported hit names a valid way holding the requested tag
    a_r2_hit_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.hit) |-> (q.valid[q.way] && q.tags[q.way] == $past(req_tag)));

    // R3: a hit way ends at age 0 or 1
    a_r3_hit_promotes: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.hit) |-> (q.ages[q.way] <= 2'd1));

    // R4: a filled way is valid at the insertion age
    a_r4_fill_state: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !q.hit) |-> (q.valid[q.way] && q.ages[q.way] == AGE_NEW));

    // R5: eviction from a full set only takes a way at the eviction age
    a_r5_victim_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && (&q.valid)) |-> (q.ages[fill_way] == AGE_MAX));

    // R6: each aging step raises every age by exactly one
    for (genvar g = 0; g < WAYS; g++) begin : g_chk
        a_r6_age_step: assert property (@(posedge clk) disable iff (!rst_n)
            (q.st == ST_AGING && !old_found) |=>
                (q.ages[g] == $past(q.ages[g]) + 2'd1));
    end

    // R7: no completion while the aging loop holds the port
    a_r7_no_done_aging: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_AGING) |-> !q.done);
endmodule

// File: tb/qage_set_repl_tb.sv
module qage_set_repl_tb_top;
    localparam int WAYS  = 16;
    localparam int TAG_W = 8;
    localparam int WAY_W = $clog2(WAYS);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0;
    logic [TAG_W-1:0]      req_tag = '0;
    logic                  req_ready;
    logic                  rsp_done, rsp_hit, rsp_evict_valid;
    logic [WAY_W-1:0]      rsp_way;
    logic [TAG_W-1:0]      rsp_evict_tag;
    logic [WAYS-1:0]       dbg_valid;
    logic [2*WAYS-1:0]     dbg_age;
    logic [TAG_W*WAYS-1:0] dbg_tag;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    int m_age   [WAYS];
    int m_tag   [WAYS];
    bit m_valid [WAYS];

    always #10 clk = ~clk;

    qage_set_repl #(.WAYS(WAYS), .TAG_W(TAG_W)) dut_i (
        .clk, .rst_n, .req_valid, .req_tag, .req_ready,
        .rsp_done, .rsp_hit, .rsp_way, .rsp_evict_valid, .rsp_evict_tag,
        .dbg_valid, .dbg_age, .dbg_tag
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        bit ok = 1'b1;
        int bad = -1;
        for (int i = 0; i < WAYS; i++) begin
            if (dbg_valid[i] != m_valid[i] || int'(dbg_age[2*i +: 2]) != m_age[i] ||
                (m_valid[i] && int'(dbg_tag[TAG_W*i +: TAG_W]) != m_tag[i])) begin
                if (ok) bad = i;
                ok = 1'b0;
            end
        end
        if (bad < 0) check(1'b1, req, "state", 0, 0);
        else check(1'b0, req, $sformatf("state age of way %0d", bad),
                   int'(dbg_age[2*bad +: 2]), m_age[bad]);
    endtask

    task automatic do_req(input int tg);
        int hw = -1, inv = -1, mx = 0, k = 0, lat = 1, way = 0, cyc = 0;
        bit ehit = 0, eev = 0;
        int etag = 0;
        string rq;
        for (int i = WAYS - 1; i >= 0; i--) if (m_valid[i] && m_tag[i] == tg) hw = i;
        if (hw >= 0) begin
            ehit = 1; way = hw; rq = "R3";
            m_age[hw] = (m_age[hw] >= 2) ? 1 : 0;
        end else begin
            for (int i = WAYS - 1; i >= 0; i--) if (!m_valid[i]) inv = i;
            if (inv >= 0) begin
                way = inv; rq = "R4";
            end else begin
                for (int i = 0; i < WAYS; i++) if (m_age[i] > mx) mx = m_age[i];
                k = 3 - mx;
                lat = k + 1;
                rq = (k > 0) ? "R6" : "R5";
                for (int i = 0; i < WAYS; i++) m_age[i] += k;
                way = -1;
                for (int i = WAYS - 1; i >= 0; i--) if (m_age[i] == 3) way = i;
                eev = 1; etag = m_tag[way];
            end
            m_tag[way] = tg; m_valid[way] = 1; m_age[way] = 1;
        end
        @(negedge clk);
        check(req_ready, "R6", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_tag = TAG_W'(tg);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_done && cyc < 40) begin
            check(!req_ready, "R6", "ready while busy", int'(req_ready), 0);
            @(negedge clk);
            cyc++;
        end
        check(cyc == lat, "R7", "done latency", cyc, lat);
        check(rsp_hit == ehit, ehit ? "R2" : rq, "hit flag", int'(rsp_hit), int'(ehit));
        check(int'(rsp_way) == way, rq, "way", int'(rsp_way), way);
        if (!ehit) begin
            check(rsp_evict_valid == eev, rq, "evict flag", int'(rsp_evict_valid), int'(eev));
            if (eev) check(int'(rsp_evict_tag) == etag, "R5", "evict tag",
                           int'(rsp_evict_tag), etag);
        end
        check_state(rq);
        @(negedge clk);
        check(!rsp_done, "R7", "done single pulse", int'(rsp_done), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] lfsr = 8'h5a;
        for (int i = 0; i < WAYS; i++) begin
            m_age[i] = 3; m_tag[i] = 0; m_valid[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready && !rsp_done, "R1", "ready after reset", int'(req_ready), 1);
        check_state("R1");
        // R2: tag 0 matches only invalid reset tags, must miss and fill way 0
        do_req(0);
        // R4: fill remaining ways in order
        for (int t = 1; t < WAYS; t++) do_req(t);
        // R3: hit, then a two-step aging miss
        do_req(5);
        do_req(100);
        // make every age 0 by hitting all ways twice, then a three-step miss
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < WAYS; i++) do_req(m_tag[i]);
        do_req(200);
        // mixed sweep over a small tag pool
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            do_req(int'(lfsr % 8'd22));
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule